// File: doc/BRIEF.md
# Doorbell and Inter-Processor Interrupt Unit

This block lets any CPU ring a doorbell on one or more CPUs, or post a message-signalled interrupt event, with a single 32-bit register write. A write to the soft-interrupt register carries a target CPU bitmap and a doorbell number. Each targeted CPU's inbound doorbell register then gets that bit set. A flag bit in the same write sends the event to a shared MSI cause register instead. Every CPU has its own inbound doorbell register and doorbell mask register. Its interrupt line is high while any set doorbell bit is also unmasked. The MSI line is high while any MSI cause bit is set.

There are two plain register ports. The global port reaches the soft-interrupt register and, when `g_sel_msi` is high, the MSI cause window. The local port carries a CPU number, `c_cpu`, which picks whose inbound and mask registers are accessed. Neither port has back-pressure: a strobe is taken in the cycle it is high. Read data comes back one cycle after the read strobe, together with a valid pulse. Both doorbell registers and the MSI cause register are cleared by writing zeros: each 0 bit in the written word clears that bit, and each 1 bit leaves it as it is.

Top module: `doorbell_unit`

## Requirements
- R1: Synchronous reset (`rst_n` low) clears every inbound doorbell, mask and MSI cause bit. Both read-valid outputs, `db_irq` and `msi_irq` are low after reset.
- R2: A global write to offset 0x04 with bit 5 clear sets doorbell bit n (n = wdata[4:0]) in the inbound register of every CPU i whose target bit wdata[8+i] is 1. Other CPUs and other bits are untouched.
- R3: Target bits at 8+NCPU and above are ignored. Global writes to any offset other than 0x04 change no state.
- R4: A global write to offset 0x04 with bit 5 set sets MSI cause bit wdata[4:0]. It changes no per-CPU doorbell, whatever the target bits are.
- R5: A local write to offset 0x08 updates the inbound register of CPU `c_cpu`: each 0 bit in the written word clears that bit, and each 1 bit leaves it unchanged.
- R6: A local write to offset 0x0c replaces the mask of CPU `c_cpu`, where a 1 enables that doorbell. `db_irq[i]` is high while CPU i has any bit that is both set and enabled.
- R7: A global write with `g_sel_msi` high to offset 0x00 clears each MSI cause bit whose written bit is 0. `msi_irq` is high while any cause bit is set.
- R8: When a soft-interrupt set and a local clear hit the same CPU's inbound register in the same cycle, the set bit ends up 1 (the set wins).
- R9: Reads return data one cycle after the strobe, with the matching valid pulse. Local reads: 0x08 returns the inbound register and 0x0c returns the mask. A global read with `g_sel_msi` high at 0x00 returns the MSI cause. Every other read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| g_wr | input | 1 | Global port write strobe |
| g_rd | input | 1 | Global port read strobe |
| g_sel_msi | input | 1 | 1 selects the MSI cause window, 0 the global window |
| g_addr | input | 8 | Global port byte offset |
| g_wdata | input | 32 | Global port write data |
| g_rvalid | output | 1 | Global read data valid |
| g_rdata | output | 32 | Global read data |
| c_wr | input | 1 | Local port write strobe |
| c_rd | input | 1 | Local port read strobe |
| c_cpu | input | 2 | CPU whose local window is accessed |
| c_addr | input | 8 | Local port byte offset |
| c_wdata | input | 32 | Local port write data |
| c_rvalid | output | 1 | Local read data valid |
| c_rdata | output | 32 | Local read data |
| db_irq | output | 4 | Per-CPU doorbell interrupt |
| msi_irq | output | 1 | MSI doorbell interrupt |

## Verification
A wrong inbound or mask bit shows at `db_irq` right after the edge that stores it, but only if the mask enables that bit. A wrong bit hidden by the mask shows only when the register is read back, one cycle after the read strobe. A lost set during a clear in the same cycle, or a soft write that leaks into a CPU it did not target, stays hidden until a later read or mask change reveals it. For that reason the bench reads every touched register after the interrupt checks.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned MAX_CPU  = 4;
  localparam int unsigned FLAG_BIT = 5;
  localparam int unsigned TGT_LSB  = 8;

  localparam logic [ADDR_W-1:0] OFS_SOFT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_INB   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h00;

  typedef enum logic [1:0] {
    LSEL_NONE = 2'd0,
    LSEL_INB  = 2'd1,
    LSEL_MASK = 2'd2
  } lsel_e;
endpackage

// File: rtl/dbu_decode.sv
module dbu_decode
  import dbu_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NUM_W = 5,
  parameter int CPU_W = 2
) (
  input  logic              g_wr,
  input  logic              g_sel_msi,
  input  logic [ADDR_W-1:0] g_addr,
  input  logic [NUM_W-1:0]  g_num,
  input  logic              g_flag,
  input  logic [NCPU-1:0]   g_tgt,
  input  logic              c_wr,
  input  logic [CPU_W-1:0]  c_cpu,
  input  logic [ADDR_W-1:0] c_addr,
  output logic [NCPU-1:0]   set_en,
  output logic [NUM_W-1:0]  set_num,
  output logic              msi_set,
  output logic              msi_clr,
  output logic [NCPU-1:0]   clr_en,
  output logic [NCPU-1:0]   mask_wr
);
  logic soft_hit;
  logic inb_hit;
  logic mask_hit;

  always_comb begin
    soft_hit = g_wr && !g_sel_msi && (g_addr == OFS_SOFT);
    msi_set  = soft_hit && g_flag;
    msi_clr  = g_wr && g_sel_msi && (g_addr == OFS_CAUSE);
    set_num  = g_num;
    inb_hit  = c_wr && (c_addr == OFS_INB);
    mask_hit = c_wr && (c_addr == OFS_MASK);
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu_sel
    logic pick;
    assign pick       = (c_cpu == CPU_W'(i));
    assign set_en[i]  = soft_hit && !g_flag && g_tgt[i];
    assign clr_en[i]  = inb_hit && pick;
    assign mask_wr[i] = mask_hit && pick;
  end
endmodule

// File: rtl/dbu_cpu_bank.sv
module dbu_cpu_bank #(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [NUM_W-1:0]  set_num,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_data,
  output logic [DATA_W-1:0] inb_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] keep_vec;
  logic [DATA_W-1:0] inb_d;

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_num] = 1'b1;
    keep_vec = clr_en ? clr_data : '1;
    // a set in the same cycle as a clear survives the clear
    inb_d = (inb_q & keep_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inb_q  <= '0;
      mask_q <= '0;
    end else begin
      inb_q <= inb_d;
      if (mask_wr) mask_q <= mask_data;
    end
  end

  assign irq = |(inb_q & mask_q);
endmodule

// File: rtl/dbu_msi_bank.sv
module dbu_msi_bank #(
  parameter int DATA_W = 32,
  parameter int NUM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [NUM_W-1:0]  set_num,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  output logic [DATA_W-1:0] cause_q,
  output logic              irq
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] cause_d;

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_num] = 1'b1;
    cause_d = (cause_q & (clr_en ? clr_data : '1)) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign irq = |cause_q;
endmodule

// File: rtl/dbu_readback.sv
module dbu_readback
  import dbu_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32,
  parameter int CPU_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCPU-1:0][DATA_W-1:0] inb_all,
  input  logic [NCPU-1:0][DATA_W-1:0] mask_all,
  input  logic [DATA_W-1:0]          cause,
  input  logic                       c_rd,
  input  logic [CPU_W-1:0]           c_cpu,
  input  logic [ADDR_W-1:0]          c_addr,
  input  logic                       g_rd,
  input  logic                       g_sel_msi,
  input  logic [ADDR_W-1:0]          g_addr,
  output logic                       c_rvalid,
  output logic [DATA_W-1:0]          c_rdata,
  output logic                       g_rvalid,
  output logic [DATA_W-1:0]          g_rdata
);
  lsel_e             lsel;
  logic              cpu_ok;
  logic [DATA_W-1:0] c_mux;
  logic [DATA_W-1:0] g_mux;

  always_comb begin
    cpu_ok = (int'(c_cpu) < NCPU);
    unique case (c_addr)
      OFS_INB:  lsel = LSEL_INB;
      OFS_MASK: lsel = LSEL_MASK;
      default:  lsel = LSEL_NONE;
    endcase
    c_mux = '0;
    if (cpu_ok) begin
      case (lsel)
        LSEL_INB:  c_mux = inb_all[c_cpu];
        LSEL_MASK: c_mux = mask_all[c_cpu];
        default:   c_mux = '0;
      endcase
    end
    g_mux = (g_sel_msi && (g_addr == OFS_CAUSE)) ? cause : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_rvalid <= 1'b0;
      g_rvalid <= 1'b0;
      c_rdata  <= '0;
      g_rdata  <= '0;
    end else begin
      c_rvalid <= c_rd;
      g_rvalid <= g_rd;
      if (c_rd) c_rdata <= c_mux;
      if (g_rd) g_rdata <= g_mux;
    end
  end
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import dbu_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32,
  localparam int NUM_W = $clog2(DATA_W),
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              g_wr,
  input  logic              g_rd,
  input  logic              g_sel_msi,
  input  logic [ADDR_W-1:0] g_addr,
  input  logic [DATA_W-1:0] g_wdata,
  output logic              g_rvalid,
  output logic [DATA_W-1:0] g_rdata,
  input  logic              c_wr,
  input  logic              c_rd,
  input  logic [CPU_W-1:0]  c_cpu,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic              c_rvalid,
  output logic [DATA_W-1:0] c_rdata,
  output logic [NCPU-1:0]   db_irq,
  output logic              msi_irq
);
  logic [NCPU-1:0]             set_en;
  logic [NUM_W-1:0]            set_num;
  logic                        msi_set;
  logic                        msi_clr;
  logic [NCPU-1:0]             clr_en;
  logic [NCPU-1:0]             mask_wr;
  logic [NCPU-1:0][DATA_W-1:0] db_q;
  logic [NCPU-1:0][DATA_W-1:0] mask_q;
  logic [DATA_W-1:0]           msi_q;

  dbu_decode #(.NCPU(NCPU), .NUM_W(NUM_W), .CPU_W(CPU_W)) u_dec (
    .g_wr     (g_wr),
    .g_sel_msi(g_sel_msi),
    .g_addr   (g_addr),
    .g_num    (g_wdata[NUM_W-1:0]),
    .g_flag   (g_wdata[FLAG_BIT]),
    .g_tgt    (g_wdata[TGT_LSB +: NCPU]),
    .c_wr     (c_wr),
    .c_cpu    (c_cpu),
    .c_addr   (c_addr),
    .set_en   (set_en),
    .set_num  (set_num),
    .msi_set  (msi_set),
    .msi_clr  (msi_clr),
    .clr_en   (clr_en),
    .mask_wr  (mask_wr)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_bank
    dbu_cpu_bank #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en[i]),
      .set_num  (set_num),
      .clr_en   (clr_en[i]),
      .clr_data (c_wdata),
      .mask_wr  (mask_wr[i]),
      .mask_data(c_wdata),
      .inb_q    (db_q[i]),
      .mask_q   (mask_q[i]),
      .irq      (db_irq[i])
    );
  end

  dbu_msi_bank #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_msi (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (msi_set),
    .set_num (set_num),
    .clr_en  (msi_clr),
    .clr_data(g_wdata),
    .cause_q (msi_q),
    .irq     (msi_irq)
  );

  dbu_readback #(.NCPU(NCPU), .DATA_W(DATA_W), .CPU_W(CPU_W)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .inb_all  (db_q),
    .mask_all (mask_q),
    .cause    (msi_q),
    .c_rd     (c_rd),
    .c_cpu    (c_cpu),
    .c_addr   (c_addr),
    .g_rd     (g_rd),
    .g_sel_msi(g_sel_msi),
    .g_addr   (g_addr),
    .c_rvalid (c_rvalid),
    .c_rdata  (c_rdata),
    .g_rvalid (g_rvalid),
    .g_rdata  (g_rdata)
  );
endmodule

// File: rtl/doorbell_unit_checker.sv
module doorbell_unit_checker
  import dbu_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32,
  localparam int NUM_W = $clog2(DATA_W),
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        g_wr,
  input logic                        g_rd,
  input logic                        g_sel_msi,
  input logic [ADDR_W-1:0]           g_addr,
  input logic [DATA_W-1:0]           g_wdata,
  input logic                        g_rvalid,
  input logic                        c_wr,
  input logic                        c_rd,
  input logic [CPU_W-1:0]            c_cpu,
  input logic [ADDR_W-1:0]           c_addr,
  input logic [DATA_W-1:0]           c_wdata,
  input logic                        c_rvalid,
  input logic [NCPU-1:0]             db_irq,
  input logic                        msi_irq,
  input logic [NCPU-1:0][DATA_W-1:0] db_q,
  input logic [NCPU-1:0][DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0]           msi_q
);
  logic soft_w;
  assign soft_w = g_wr && !g_sel_msi && (g_addr == OFS_SOFT);

  for (genvar i = 0; i < NCPU; i++) begin : g_chk
    // R2 and R8: a targeted set is present after the edge, even with a clear
    a_r2_target_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_w && !g_wdata[FLAG_BIT] && g_wdata[TGT_LSB+i])
      |-> db_q[i][$past(g_wdata[NUM_W-1:0])]);

    // R5: a local clear without a set behaves as AND with the written word
    a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(c_wr && (c_addr == OFS_INB) && (c_cpu == CPU_W'(i)))
       && !$past(soft_w && !g_wdata[FLAG_BIT] && g_wdata[TGT_LSB+i]))
      |-> (db_q[i] == ($past(db_q[i]) & $past(c_wdata))));

    // R6: a doorbell interrupt only rises after some write
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(db_irq[i]) |-> $past(g_wr || c_wr));
  end

  // R4: a flagged soft write lands in the MSI cause register
  a_r4_msi_set: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_w && g_wdata[FLAG_BIT])
    |-> msi_q[$past(g_wdata[NUM_W-1:0])]);

  // R4: a flagged soft write leaves the per-CPU doorbells alone
  a_r4_no_cpu_touch: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_w && g_wdata[FLAG_BIT] && !c_wr) |-> $stable(db_q));

  // R3: with no write in the previous cycle no register moves
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!g_wr && !c_wr) |-> ($stable(db_q) && $stable(mask_q) && $stable(msi_q)));

  // R7: the MSI interrupt only rises after a flagged soft write
  a_r7_msi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_irq) |-> $past(soft_w && g_wdata[FLAG_BIT]));

  // R9: read data valid follows the strobe by one cycle
  a_r9_local_valid: assert property (@(posedge clk) disable iff (!rst_n)
    c_rvalid == $past(c_rd));
  a_r9_global_valid: assert property (@(posedge clk) disable iff (!rst_n)
    g_rvalid == $past(g_rd));
endmodule

bind doorbell_unit doorbell_unit_checker #(.NCPU(NCPU), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .g_wr     (g_wr),
  .g_rd     (g_rd),
  .g_sel_msi(g_sel_msi),
  .g_addr   (g_addr),
  .g_wdata  (g_wdata),
  .g_rvalid (g_rvalid),
  .c_wr     (c_wr),
  .c_rd     (c_rd),
  .c_cpu    (c_cpu),
  .c_addr   (c_addr),
  .c_wdata  (c_wdata),
  .c_rvalid (c_rvalid),
  .db_irq   (db_irq),
  .msi_irq  (msi_irq),
  .db_q     (db_q),
  .mask_q   (mask_q),
  .msi_q    (msi_q)
);

// File: tb/doorbell_unit_test.sv
module doorbell_unit_test;
  localparam int CLK_P = 10;
  localparam int NV    = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        g_wr = 1'b0, g_rd = 1'b0, g_sel_msi = 1'b0;
  logic [7:0]  g_addr = '0;
  logic [31:0] g_wdata = '0;
  logic        g_rvalid;
  logic [31:0] g_rdata;
  logic        c_wr = 1'b0, c_rd = 1'b0;
  logic [1:0]  c_cpu = '0;
  logic [7:0]  c_addr = '0;
  logic [31:0] c_wdata = '0;
  logic        c_rvalid;
  logic [31:0] c_rdata;
  logic [3:0]  db_irq;
  logic        msi_irq;

  int checks = 0;
  int errors = 0;

  doorbell_unit uut (
    .clk(clk), .rst_n(rst_n),
    .g_wr(g_wr), .g_rd(g_rd), .g_sel_msi(g_sel_msi), .g_addr(g_addr),
    .g_wdata(g_wdata), .g_rvalid(g_rvalid), .g_rdata(g_rdata),
    .c_wr(c_wr), .c_rd(c_rd), .c_cpu(c_cpu), .c_addr(c_addr),
    .c_wdata(c_wdata), .c_rvalid(c_rvalid), .c_rdata(c_rdata),
    .db_irq(db_irq), .msi_irq(msi_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // fields: kind(0 global,1 msi window,2 local) cpu addr wdata exp_db_irq exp_msi
  localparam logic [55:0] VEC [NV] = '{
    {4'd2, 4'd0, 8'h0C, 32'hFFFFFFFF, 4'h0, 4'h0},  // R6 unmask all on cpu0
    {4'd2, 4'd1, 8'h0C, 32'h00000008, 4'h0, 4'h0},  // R6 cpu1 enables bit 3 only
    {4'd0, 4'd0, 8'h04, 32'h00000103, 4'h1, 4'h0},  // R2 cpu0 bit 3
    {4'd0, 4'd0, 8'h04, 32'h00000E07, 4'h1, 4'h0},  // R2 cpus 1..3 bit 7, masked
    {4'd0, 4'd0, 8'h04, 32'h00000203, 4'h3, 4'h0},  // R2 cpu1 bit 3, enabled
    {4'd0, 4'd0, 8'h04, 32'h0000F125, 4'h3, 4'h1},  // R4 flagged: MSI bit 5 only
    {4'd2, 4'd0, 8'h08, 32'hFFFFFFF7, 4'h2, 4'h1},  // R5 clear cpu0 bit 3
    {4'd2, 4'd1, 8'h08, 32'hFFFFFF7F, 4'h2, 4'h1},  // R5 clear cpu1 bit 7, bit 3 stays
    {4'd1, 4'd0, 8'h00, 32'hFFFFFFDF, 4'h2, 4'h0},  // R7 clear MSI bit 5
    {4'd0, 4'd0, 8'h04, 32'h0000F01F, 4'h2, 4'h0},  // R3 absent targets only
    {4'd2, 4'd1, 8'h08, 32'h00000000, 4'h0, 4'h0},  // R5 clear all cpu1
    {4'd2, 4'd2, 8'h0C, 32'hFFFFFFFF, 4'h4, 4'h0},  // R6 unmask reveals cpu2 bit 7
    {4'd2, 4'd2, 8'h10, 32'h00000000, 4'h4, 4'h0},  // R3 unmapped local offset
    {4'd0, 4'd0, 8'h08, 32'h00000F01, 4'h4, 4'h0}   // R3 other global offset
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic gwrite(input logic msi, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    g_wr = 1'b1; g_sel_msi = msi; g_addr = a; g_wdata = d;
    @(negedge clk);
    g_wr = 1'b0;
  endtask

  task automatic cwrite(input logic [1:0] cpu, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    c_wr = 1'b1; c_cpu = cpu; c_addr = a; c_wdata = d;
    @(negedge clk);
    c_wr = 1'b0;
  endtask

  task automatic cread(input string tag, input logic [1:0] cpu, input logic [7:0] a,
                       input logic [31:0] exp);
    @(negedge clk);
    c_rd = 1'b1; c_cpu = cpu; c_addr = a;
    @(negedge clk);
    c_rd = 1'b0;
    chk({tag, " valid"}, {31'd0, c_rvalid}, 32'd1);
    chk(tag, c_rdata, exp);
  endtask

  task automatic gread(input string tag, input logic msi, input logic [7:0] a,
                       input logic [31:0] exp);
    @(negedge clk);
    g_rd = 1'b1; g_sel_msi = msi; g_addr = a;
    @(negedge clk);
    g_rd = 1'b0;
    chk({tag, " valid"}, {31'd0, g_rvalid}, 32'd1);
    chk(tag, g_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog (all requirements) act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 db_irq after reset", {28'd0, db_irq}, 32'd0);
    chk("R1 msi_irq after reset", {31'd0, msi_irq}, 32'd0);
    chk("R1 rvalid idle", {30'd0, c_rvalid, g_rvalid}, 32'd0);
    cread("R1 cpu0 mask reset", 2'd0, 8'h0C, 32'h0);
    gread("R1 msi cause reset", 1'b1, 8'h00, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [55:0] v;
      v = VEC[k];
      case (v[55:52])
        4'd0:    gwrite(1'b0, v[47:40], v[39:8]);
        4'd1:    gwrite(1'b1, v[47:40], v[39:8]);
        default: cwrite(v[49:48], v[47:40], v[39:8]);
      endcase
      chk($sformatf("table %0d db_irq (R2..R7)", k), {28'd0, db_irq}, {28'd0, v[7:4]});
      chk($sformatf("table %0d msi_irq (R4/R7)", k), {31'd0, msi_irq}, {31'd0, v[0]});
    end

    // register contents left by the table
    cread("R2 cpu2 inbound bit 7", 2'd2, 8'h08, 32'h00000080);
    cread("R2 cpu3 inbound bit 7", 2'd3, 8'h08, 32'h00000080);
    cread("R5 cpu0 inbound cleared", 2'd0, 8'h08, 32'h0);
    cread("R6 cpu1 mask readback", 2'd1, 8'h0C, 32'h00000008);
    cread("R6 cpu3 mask untouched", 2'd3, 8'h0C, 32'h0);
    cread("R9 local unmapped read", 2'd2, 8'h10, 32'h0);
    gread("R9 global soft register reads zero", 1'b0, 8'h04, 32'h0);

    // R8: set to cpu3 bit 9 while cpu3 clears everything in the same cycle
    @(negedge clk);
    g_wr = 1'b1; g_sel_msi = 1'b0; g_addr = 8'h04; g_wdata = 32'h00000809;
    c_wr = 1'b1; c_cpu = 2'd3; c_addr = 8'h08; c_wdata = 32'h0;
    @(negedge clk);
    g_wr = 1'b0; c_wr = 1'b0;
    cread("R8 set survives same-cycle clear", 2'd3, 8'h08, 32'h00000200);

    // R4/R7: MSI bits 0 and 31, then zero-write clearing
    gwrite(1'b0, 8'h04, 32'h00000020);
    gwrite(1'b0, 8'h04, 32'h0000003F);
    chk("R7 msi_irq with cause set", {31'd0, msi_irq}, 32'd1);
    gread("R4 msi cause bits 0 and 31", 1'b1, 8'h00, 32'h80000001);
    gwrite(1'b1, 8'h00, 32'hFFFFFFFE);
    gread("R7 msi clear bit 0 keeps bit 31", 1'b1, 8'h00, 32'h80000000);
    chk("R7 msi_irq still high", {31'd0, msi_irq}, 32'd1);
    gwrite(1'b1, 8'h00, 32'h7FFFFFFF);
    chk("R7 msi_irq low when empty", {31'd0, msi_irq}, 32'd0);
    gread("R9 msi window other offset", 1'b1, 8'h04, 32'h0);

    // R1: reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 db_irq after second reset", {28'd0, db_irq}, 32'd0);
    cread("R1 cpu2 inbound after reset", 2'd2, 8'h08, 32'h0);
    cread("R1 cpu2 mask after reset", 2'd2, 8'h0C, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule